// File: doc/BRIEF.md
# Asynchronous Static RAM Access Controller

This block lets a clocked host use an external asynchronous static RAM of 64K words by 16 bits. The RAM has a separate active-low enable for each byte. The host presents one request at a time: an address, write data, a two-bit lane mask and a read/write flag, qualified by a valid signal. The request is taken only when the ready output is high. The controller then walks the RAM's active-low strobes through a fixed sequence of clock cycles.

All timing is counted in whole clock periods. Three parameters set these counts: the write pulse length, the read access length and the length of the idle gap between a read and a write. The integrator derives each one by rounding the RAM's nanosecond minimum up to whole periods of the chosen clock. Read data comes back one cycle after the access, with a single-cycle valid pulse. The controller drives the shared data bus only while a write pulse is active. It also inserts a quiet gap when a write follows straight after a read, so that the two drivers never overlap.

Top module: `asram_ctrl`

## Requirements
- R1: While reset is held and after it is released, with no request: ready is 1, chip select, write strobe and output strobe are all 1 (inactive), the bus driver enable is 0, and read-valid is 0.
- R2: A write of a full word (mask 2'b11), followed by a read of the same address with mask 2'b11, returns the written word.
- R3: Mask bit 0 selects the low lane, data bits 7:0, through the active-low low-byte enable. Mask bit 1 selects the high lane, data bits 15:8, through the active-low high-byte enable. A write changes only the lanes whose mask bit is 1. A write with mask 2'b00 leaves the word unchanged.
- R4: On a read, any lane whose mask bit is 0 is returned as zero, whatever the RAM presents on that lane.
- R5: During a write, chip select and the write strobe are low together for exactly WR_CYC consecutive cycles.
- R6: The read-valid pulse is high in the cycle RD_CYC clock edges after the accepting edge, and lasts exactly one cycle.
- R7: When a write is accepted in the cycle of a read-valid pulse, the write strobe first goes low TURN_CYC cycles after acceptance, and stays high meanwhile. A write that does not directly follow a read pulls the write strobe low in the first cycle after acceptance.
- R8: Ready is low in the cycle after a request is accepted, and stays low until the access ends.
- R9: The bus driver enable is high only while chip select and the write strobe are low and the output strobe is high. The RAM is never enabled to drive the bus while the controller drives it.
- R10: Address, write data and mask are captured on the accepting edge. Changes to those inputs during the access have no effect on it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| reqValid | input | 1 | Host request present |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | 16 | Word address |
| reqWdata | input | 16 | Write data |
| reqMask | input | 2 | Lane select, bit 0 low byte, bit 1 high byte |
| reqReady | output | 1 | Controller can take a request |
| rdData | output | 16 | Read data, disabled lanes zero |
| rdValid | output | 1 | One-cycle pulse with read data |
| memCeN | output | 1 | RAM chip select, active low |
| memWeN | output | 1 | RAM write strobe, active low |
| memOeN | output | 1 | RAM output strobe, active low |
| memLbN | output | 1 | RAM low-byte enable, active low |
| memUbN | output | 1 | RAM high-byte enable, active low |
| memAddr | output | 16 | RAM address |
| memDqOut | output | 16 | Data toward RAM |
| memDqIn | input | 16 | Data from RAM |
| memDqOe | output | 1 | Enable for the controller's bus driver |

## Verification
The assertions assume that the host raises reqValid only to hand over a request, and that it does not treat a request as taken unless ready was high at the same edge. They also assume that the RAM's data settles within RD_CYC cycles of the output strobe going low. The stimulus keeps to these assumptions. Requests are driven on falling edges, and only after ready has been seen high, and they are withdrawn one cycle later. The fields are then scrambled on purpose while the access runs. The RAM model answers combinationally and puts a fixed filler byte on lanes that are not enabled, so the zeroing of masked lanes is visible at the ports.

// File: rtl/asram_pkg.sv
package asram_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_READ  = 2'd1,
    ST_WRITE = 2'd2,
    ST_TURN  = 2'd3
  } ctlState_t;

  typedef struct packed {
    logic load;     // take host request this cycle
    logic selN;     // chip select level
    logic writeN;   // write strobe level
    logic readN;    // output strobe level
    logic laneOn;   // open byte enables selected by the mask
    logic drive;    // controller drives the bus
    logic capture;  // sample read data at this edge
  } strobe_t;
endpackage

// File: rtl/asram_ctrl_fsm.sv
module asram_ctrl_fsm
  import asram_pkg::*;
#(
  parameter int WR_CYC   = 1,
  parameter int RD_CYC   = 2,
  parameter int TURN_CYC = 1
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    reqValid,
  input  logic    reqWrite,
  output logic    reqReady,
  output strobe_t stb
);
  localparam int MAX_A = (WR_CYC > RD_CYC) ? WR_CYC : RD_CYC;
  localparam int MAX_C = (MAX_A > TURN_CYC) ? MAX_A : TURN_CYC;
  localparam int CNT_W = (MAX_C > 1) ? $clog2(MAX_C) : 1;
  localparam bit USE_TURN = (TURN_CYC > 0);

  ctlState_t stateQ, stateD;
  logic [CNT_W-1:0] cntQ, cntD;
  logic justReadQ;
  logic wrDone, rdDone, turnDone, accept;

  assign wrDone   = (cntQ == CNT_W'(WR_CYC - 1));
  assign rdDone   = (cntQ == CNT_W'(RD_CYC - 1));
  assign turnDone = (cntQ == CNT_W'(TURN_CYC - 1));
  assign reqReady = (stateQ == ST_IDLE);
  assign accept   = reqReady && reqValid;

  always_comb begin
    stateD = stateQ;
    cntD   = cntQ + CNT_W'(1);
    unique case (stateQ)
      ST_IDLE: begin
        cntD = '0;
        if (accept) begin
          if (!reqWrite)                  stateD = ST_READ;
          else if (USE_TURN && justReadQ) stateD = ST_TURN;
          else                            stateD = ST_WRITE;
        end
      end
      ST_READ: if (rdDone) begin
        stateD = ST_IDLE;
        cntD   = '0;
      end
      ST_WRITE: if (wrDone) begin
        stateD = ST_IDLE;
        cntD   = '0;
      end
      ST_TURN: if (turnDone) begin
        stateD = ST_WRITE;
        cntD   = '0;
      end
      default: stateD = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ    <= ST_IDLE;
      cntQ      <= '0;
      justReadQ <= 1'b0;
    end else begin
      stateQ    <= stateD;
      cntQ      <= cntD;
      justReadQ <= (stateQ == ST_READ) && rdDone;
    end
  end

  always_comb begin
    stb.load    = accept;
    stb.selN    = !((stateQ == ST_READ) || (stateQ == ST_WRITE));
    stb.writeN  = (stateQ != ST_WRITE);
    stb.readN   = (stateQ != ST_READ);
    stb.laneOn  = (stateQ == ST_READ) || (stateQ == ST_WRITE);
    stb.drive   = (stateQ == ST_WRITE);
    stb.capture = (stateQ == ST_READ) && rdDone;
  end

  // R8: once accepted, the controller is busy on the next cycle
  assert_busy_after_accept_R8: assert property (@(posedge clk) disable iff (!rstN)
    accept |=> !reqReady);

  // R6: a capture is never followed directly by another capture
  assert_single_capture_R6: assert property (@(posedge clk) disable iff (!rstN)
    stb.capture |=> !stb.capture);
endmodule

// File: rtl/asram_ctrl_dp.sv
module asram_ctrl_dp
  import asram_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           stb,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic [1:0]        reqMask,
  output logic [DATA_W-1:0] rdData,
  output logic              rdValid,
  output logic              memCeN,
  output logic              memWeN,
  output logic              memOeN,
  output logic [1:0]        memBeN,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memDqOut,
  input  logic [DATA_W-1:0] memDqIn,
  output logic              memDqOe
);
  localparam int LANES  = 2;
  localparam int LANE_W = DATA_W / LANES;

  logic [ADDR_W-1:0] addrQ;
  logic [DATA_W-1:0] wdataQ;
  logic [LANES-1:0]  maskQ;
  logic [DATA_W-1:0] rdDataQ;
  logic              rdValidQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ    <= '0;
      wdataQ   <= '0;
      maskQ    <= '0;
      rdValidQ <= 1'b0;
    end else begin
      rdValidQ <= stb.capture;
      if (stb.load) begin
        addrQ  <= reqAddr;
        wdataQ <= reqWdata;
        maskQ  <= reqMask;
      end
    end
  end

  for (genvar g = 0; g < LANES; g++) begin : gLane
    assign memBeN[g] = !(stb.laneOn && maskQ[g]);
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)
        rdDataQ[g*LANE_W +: LANE_W] <= '0;
      else if (stb.capture)
        rdDataQ[g*LANE_W +: LANE_W] <= maskQ[g] ? memDqIn[g*LANE_W +: LANE_W] : '0;
    end
  end

  assign memCeN   = stb.selN;
  assign memWeN   = stb.writeN;
  assign memOeN   = stb.readN;
  assign memAddr  = addrQ;
  assign memDqOut = wdataQ;
  assign memDqOe  = stb.drive;
  assign rdData   = rdDataQ;
  assign rdValid  = rdValidQ;

  // R4: a lane that was not selected reads back as zero
  assert_masked_lane_zero_R4: assert property (@(posedge clk) disable iff (!rstN)
    (rdValid && !maskQ[0]) |-> (rdData[LANE_W-1:0] == '0));
endmodule

// File: rtl/asram_ctrl.sv
module asram_ctrl
  import asram_pkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter int DATA_W   = 16,
  parameter int WR_CYC   = 1,
  parameter int RD_CYC   = 2,
  parameter int TURN_CYC = 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic [1:0]        reqMask,
  output logic              reqReady,
  output logic [DATA_W-1:0] rdData,
  output logic              rdValid,
  output logic              memCeN,
  output logic              memWeN,
  output logic              memOeN,
  output logic              memLbN,
  output logic              memUbN,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memDqOut,
  input  logic [DATA_W-1:0] memDqIn,
  output logic              memDqOe
);
  strobe_t    stb;
  logic [1:0] beN;

  asram_ctrl_fsm #(.WR_CYC(WR_CYC), .RD_CYC(RD_CYC), .TURN_CYC(TURN_CYC)) i_fsm (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqReady(reqReady), .stb(stb)
  );

  asram_ctrl_dp #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .reqAddr(reqAddr), .reqWdata(reqWdata),
    .reqMask(reqMask), .rdData(rdData), .rdValid(rdValid), .memCeN(memCeN),
    .memWeN(memWeN), .memOeN(memOeN), .memBeN(beN), .memAddr(memAddr),
    .memDqOut(memDqOut), .memDqIn(memDqIn), .memDqOe(memDqOe)
  );

  assign memLbN = beN[0];
  assign memUbN = beN[1];

  // R9: controller drives the bus only inside a write, never against a read
  assert_drive_only_write_R9: assert property (@(posedge clk) disable iff (!rstN)
    memDqOe |-> (!memCeN && !memWeN && memOeN));

  // R6: read-valid is a single-cycle pulse
  assert_valid_pulse_R6: assert property (@(posedge clk) disable iff (!rstN)
    rdValid |=> !rdValid);

  // R10: the address presented to the RAM is held while busy
  assert_addr_held_R10: assert property (@(posedge clk) disable iff (!rstN)
    (!reqReady && $past(!reqReady)) |-> $stable(memAddr));

  if (TURN_CYC > 0) begin : gTurnChk
    // R7: a write taken right after a read starts with a quiet cycle
    assert_turn_gap_R7: assert property (@(posedge clk) disable iff (!rstN)
      (rdValid && reqValid && reqReady && reqWrite) |=> (memWeN && !memDqOe));
  end
endmodule

// File: tb/test_asram_ctrl.sv
module test_asram_ctrl;
  localparam int TB_WR   = 2;
  localparam int TB_RD   = 3;
  localparam int TB_TURN = 1;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0, reqWrite = 1'b0;
  logic [15:0] reqAddr = '0, reqWdata = '0;
  logic [1:0] reqMask = '0;
  logic reqReady, rdValid, memCeN, memWeN, memOeN, memLbN, memUbN, memDqOe;
  logic [15:0] rdData, memAddr, memDqOut, memDqIn;

  always #5 clk = ~clk;

  asram_ctrl #(.WR_CYC(TB_WR), .RD_CYC(TB_RD), .TURN_CYC(TB_TURN)) i_asram_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqAddr(reqAddr), .reqWdata(reqWdata), .reqMask(reqMask),
    .reqReady(reqReady), .rdData(rdData), .rdValid(rdValid),
    .memCeN(memCeN), .memWeN(memWeN), .memOeN(memOeN), .memLbN(memLbN),
    .memUbN(memUbN), .memAddr(memAddr), .memDqOut(memDqOut),
    .memDqIn(memDqIn), .memDqOe(memDqOe)
  );

  int total = 0, bad = 0, cyc = 0, busErr = 0;
  int acceptCyc = 0, lastRdCyc = 0, weStart = 0, weLen = 0, lastWeLen = 0;
  logic prevWeN = 1'b1;
  logic [15:0] expQ[$];
  logic [15:0] ram [256];
  logic [15:0] rdWord;
  logic rdOn;

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  // RAM model: combinational read, filler on disabled lanes
  assign rdWord = ram[memAddr[7:0]];
  assign rdOn = !memCeN && !memOeN && memWeN;
  assign memDqIn[7:0]  = (rdOn && !memLbN) ? rdWord[7:0]  : 8'hA5;
  assign memDqIn[15:8] = (rdOn && !memUbN) ? rdWord[15:8] : 8'hA5;

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (!memCeN && !memWeN) begin
      if (!memDqOe) busErr++;
      if (!memLbN) ram[memAddr[7:0]][7:0]  <= memDqOut[7:0];
      if (!memUbN) ram[memAddr[7:0]][15:8] <= memDqOut[15:8];
    end
    if (memDqOe && (rdOn || memWeN || memCeN)) busErr++;
    if (!memWeN && prevWeN) begin weStart = cyc; weLen = 1; end
    else if (!memWeN) weLen++;
    else if (!prevWeN) lastWeLen = weLen;
    prevWeN = memWeN;
    // scoreboard monitor
    if (rdValid) begin
      lastRdCyc = cyc;
      if (expQ.size() == 0) check(1'b0, "R2 unexpected read", {16'h0, rdData}, 32'h0);
      else begin
        logic [15:0] e;
        e = expQ.pop_front();
        check(rdData == e, "R2/R3/R4/R10 read data", {16'h0, rdData}, {16'h0, e});
      end
    end
  end

  task automatic access(input bit wr, input logic [15:0] a, input logic [15:0] d,
                        input logic [1:0] m, input logic [15:0] e);
    @(negedge clk);
    while (!reqReady) @(negedge clk);
    reqValid = 1'b1; reqWrite = wr; reqAddr = a; reqWdata = d; reqMask = m;
    if (!wr) expQ.push_back(e);
    @(negedge clk);
    acceptCyc = cyc;
    reqValid = 1'b0;
    reqAddr = ~a; reqWdata = ~d; reqMask = ~m;   // R10: scramble while busy
    check(!reqReady, "R8 ready low after accept", {31'h0, reqReady}, 32'h0);
  endtask

  task automatic drain();
    for (int i = 0; i < 20 && (expQ.size() != 0 || !reqReady); i++) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) ram[i] = 16'h0;
    repeat (2) @(negedge clk);
    // R1 reset state
    check(reqReady && memCeN && memWeN && memOeN && !memDqOe && !rdValid,
          "R1 in reset", {26'h0, reqReady, memCeN, memWeN, memOeN, memDqOe, rdValid}, 32'h3C);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    check(reqReady && memCeN && memWeN && memOeN && !memDqOe && !rdValid,
          "R1 after reset", {26'h0, reqReady, memCeN, memWeN, memOeN, memDqOe, rdValid}, 32'h3C);

    // R2 full word, R5 pulse length
    access(1'b1, 16'h1234, 16'hBEEF, 2'b11, 16'h0);
    drain();
    check(lastWeLen == TB_WR, "R5 write pulse cycles", lastWeLen, TB_WR);
    check(weStart - acceptCyc == 0, "R7 no gap without read", weStart - acceptCyc, 0);
    access(1'b0, 16'h1234, 16'h0, 2'b11, 16'hBEEF);
    drain();
    check(lastRdCyc - acceptCyc == TB_RD, "R6 read latency", lastRdCyc - acceptCyc, TB_RD);

    // R3 lane writes
    access(1'b1, 16'h1234, 16'h0011, 2'b01, 16'h0);
    access(1'b0, 16'h1234, 16'h0, 2'b11, 16'hBE11);
    access(1'b1, 16'h1234, 16'h7700, 2'b10, 16'h0);
    access(1'b0, 16'h1234, 16'h0, 2'b11, 16'h7711);
    // R4 masked reads
    access(1'b0, 16'h1234, 16'h0, 2'b01, 16'h0011);
    access(1'b0, 16'h1234, 16'h0, 2'b10, 16'h7700);
    access(1'b0, 16'h1234, 16'h0, 2'b00, 16'h0000);
    drain();

    // R7 read then immediate write
    access(1'b0, 16'hFF01, 16'h0, 2'b11, 16'h0000);
    access(1'b1, 16'hFF01, 16'hCAFE, 2'b11, 16'h0);
    drain();
    check(weStart - acceptCyc == TB_TURN, "R7 turnaround gap", weStart - acceptCyc, TB_TURN);
    access(1'b0, 16'hFF01, 16'h0, 2'b11, 16'hCAFE);
    drain();

    // R3 mask 00 write leaves word; R10 scrambled inputs
    access(1'b1, 16'h0042, 16'h1111, 2'b11, 16'h0);
    access(1'b1, 16'h0042, 16'hFFFF, 2'b00, 16'h0);
    access(1'b0, 16'h0042, 16'h0, 2'b11, 16'h1111);
    access(1'b1, 16'h8000, 16'h5A5A, 2'b11, 16'h0);
    access(1'b0, 16'h8000, 16'h0, 2'b11, 16'h5A5A);
    drain();

    check(expQ.size() == 0, "R6 all reads returned", expQ.size(), 0);
    check(busErr == 0, "R9 bus ownership", busErr, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    wait (cyc > 20000);
    total++; bad++;
    $display("FAIL watchdog act=%0d exp=%0d", cyc, 20000);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule